// File: doc/BRIEF.md
# Card Clock Divider Calculator

This block works out the settings for a storage-card module clock generator from a requested card clock frequency in Hz. It scales the request for the controller's timing mode, picks either a fixed crystal oscillator or a faster PLL as the source, and splits the ceiling division into a linear stage of 1 to 16 and a power-of-two stage of 1, 2, 4 or 8. It also chooses output and sample phase delay codes from frequency bands. All of the results are registered.

Software or a sequencer puts a request on `reqHz` together with the mode flags and pulses `start`. The block stays busy for about seventy cycles, because it uses one shared shift-subtract divider twice. It then pulses `done`, with `err` telling whether the request could be met. The block also returns the rate the settings actually give, so that it can be compared with the request. It only computes settings and does not generate any clock.

Top module: `clk_div_calc`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0 and every settings output (`srcSel`, `preExp`, `linDiv`, `oclkDly`, `sclkDly`, `dlyApply`, `postDiv`, `achievedHz`) is 0.
- R2: The working frequency is the request multiplied by 2 when `newMode` is 1. It is multiplied by 2 again when `ddrMode` is 1, so it is 4x when both flags are 1.
- R3: `srcSel` is 0 (the oscillator, OSC_HZ = 24 MHz) when the working frequency is at or below OSC_HZ. Otherwise it is 1 (the PLL, PLL_HZ = 600 MHz).
- R4: The divider starts at ceil(source / working frequency). While it is above 16, `preExp` is incremented and the divider becomes floor((div+1)/2). On success, `linDiv` holds the final divider (1..16) and `preExp` the exponent (0..3).
- R5: If the exponent would have to exceed 3, `err` is 1 and all settings outputs and `achievedHz` keep their previous values.
- R6: A request of 0 gives `err` = 1 and leaves all settings outputs unchanged.
- R7: The delay codes (output/sample) depend on the working frequency, and each band's upper limit is inclusive. Up to 400 kHz the codes are 0/0, up to 25 MHz 0/5, up to 52 MHz 3/4, and above that 1/4.
- R8: The band codes are driven, and `dlyApply` is 1, only when both `newMode` and `calMode` are 0. Otherwise `oclkDly` = `sclkDly` = 0 and `dlyApply` = 0.
- R9: `postDiv` is 1 when `ddrMode` was 1 for the request and 0 otherwise.
- R10: On success, `achievedHz` = floor(floor(source / 2^preExp) / linDiv).
- R11: `start` is accepted only while idle. `busy` stays 1 from the cycle after acceptance until the result is ready. `done` is a one-cycle pulse with `busy` at 0. A `start` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calculation (taken only when idle) |
| reqHz | input | 32 | Requested card clock in Hz |
| newMode | input | 1 | New timing mode flag (doubles request, suppresses delays) |
| ddrMode | input | 1 | Double data rate flag (doubles request, sets post-divide) |
| calMode | input | 1 | Delay calibration present (suppresses delay codes) |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request could not be met |
| srcSel | output | 1 | 0 = oscillator, 1 = PLL |
| preExp | output | 2 | Power-of-two pre-divider exponent |
| linDiv | output | 5 | Linear divider, 1..16 |
| oclkDly | output | 3 | Output phase delay code |
| sclkDly | output | 3 | Sample phase delay code |
| dlyApply | output | 1 | Delay codes are in force |
| postDiv | output | 1 | Internal post-divide field |
| achievedHz | output | 32 | Rate the settings produce |

## Verification
The bench aims at the inclusive band and source limits (24 MHz, 25 MHz, 400 kHz and one Hz above each). A design that uses strict comparisons there would choose the PLL, or the wrong delay codes, on exactly those requests. It runs one request that needs exactly three folds and one that needs four. An off-by-one in the exponent check would reject the first or accept the second, and a design that writes partial results on failure would corrupt the held settings. It also covers a zero request, which would hang or give garbage without an explicit guard, and a second `start` pulsed mid-calculation, which a careless handshake would pick up and use to replace the first request.

// File: rtl/clkcalc_pkg.sv
package clkcalc_pkg;
  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic capture;
    logic init1;
    logic divStep;
    logic takeCeil;
    logic foldStep;
    logic init2;
    logic commit;
  } calc_cmd_t;

  // conditions reported back to the control FSM
  typedef struct packed {
    logic zeroReq;
    logic foldNeed;
    logic expOver;
  } calc_stat_t;
endpackage

// File: rtl/clkcalc_dp.sv
module clkcalc_dp
  import clkcalc_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int OSC_HZ  = 24_000_000,
  parameter int PLL_HZ  = 600_000_000,
  parameter int DIV_MAX = 16,
  parameter int EXP_MAX = 3,
  parameter int LOW_BAND_HZ  = 400_000,
  parameter int MID_BAND_HZ  = 25_000_000,
  parameter int HIGH_BAND_HZ = 52_000_000,
  localparam int DIV_W = $clog2(DIV_MAX + 1),
  localparam int EXP_W = $clog2(EXP_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  calc_cmd_t         cmd,
  output calc_stat_t        stat,
  input  logic [FREQ_W-1:0] reqHz,
  input  logic              newMode,
  input  logic              ddrMode,
  input  logic              calMode,
  output logic              srcSel,
  output logic [EXP_W-1:0]  preExp,
  output logic [DIV_W-1:0]  linDiv,
  output logic [2:0]        oclkDly,
  output logic [2:0]        sclkDly,
  output logic              dlyApply,
  output logic              postDiv,
  output logic [FREQ_W-1:0] achievedHz
);
  localparam int SW = FREQ_W + 2;
  localparam logic [FREQ_W-1:0] OSC_V = FREQ_W'(OSC_HZ);
  localparam logic [FREQ_W-1:0] PLL_V = FREQ_W'(PLL_HZ);

  logic [SW-1:0]     scaledQ, denQ, remQ;
  logic [FREQ_W-1:0] quoQ, divVal;
  logic [EXP_W:0]    expN;
  logic              newQ, ddrQ, calQ;

  logic              srcIsPll, fits, applied;
  logic [FREQ_W-1:0] srcV, ceilVal;
  logic [SW:0]       remShift, remNext;
  logic [2:0]        oBand, sBand;
  logic [1:0]        shAmt;

  assign shAmt    = {1'b0, newMode} + {1'b0, ddrMode};
  assign srcIsPll = scaledQ > SW'(OSC_HZ);
  assign srcV     = srcIsPll ? PLL_V : OSC_V;
  assign remShift = {remQ, quoQ[FREQ_W-1]};
  assign fits     = remShift >= {1'b0, denQ};
  assign remNext  = fits ? remShift - {1'b0, denQ} : remShift;
  assign ceilVal  = quoQ + FREQ_W'(remQ != '0);
  assign applied  = !newQ && !calQ;

  assign stat.zeroReq  = (scaledQ == '0);
  assign stat.foldNeed = divVal > FREQ_W'(DIV_MAX);
  assign stat.expOver  = expN > (EXP_W + 1)'(EXP_MAX);

  always_comb begin
    if (scaledQ <= SW'(LOW_BAND_HZ)) begin
      oBand = 3'd0; sBand = 3'd0;
    end else if (scaledQ <= SW'(MID_BAND_HZ)) begin
      oBand = 3'd0; sBand = 3'd5;
    end else if (scaledQ <= SW'(HIGH_BAND_HZ)) begin
      oBand = 3'd3; sBand = 3'd4;
    end else begin
      oBand = 3'd1; sBand = 3'd4;
    end
  end

  // working registers: request, shared divider, fold stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scaledQ <= '0; denQ <= '0; remQ <= '0; quoQ <= '0;
      divVal <= '0; expN <= '0; newQ <= 1'b0; ddrQ <= 1'b0; calQ <= 1'b0;
    end else begin
      if (cmd.capture) begin
        scaledQ <= SW'(reqHz) << shAmt;
        newQ <= newMode; ddrQ <= ddrMode; calQ <= calMode;
      end
      if (cmd.init1) begin
        remQ <= '0; quoQ <= srcV; denQ <= scaledQ;
      end
      if (cmd.divStep) begin
        quoQ <= {quoQ[FREQ_W-2:0], fits};
        remQ <= remNext[SW-1:0];
      end
      if (cmd.takeCeil) begin
        divVal <= ceilVal; expN <= '0;
      end
      if (cmd.foldStep) begin
        expN   <= expN + 1'b1;
        divVal <= FREQ_W'((divVal + 1'b1) >> 1);
      end
      if (cmd.init2) begin
        remQ <= '0; quoQ <= srcV >> expN; denQ <= SW'(divVal);
      end
    end
  end

  // result registers, written only on a successful commit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srcSel <= 1'b0; preExp <= '0; linDiv <= '0; oclkDly <= '0;
      sclkDly <= '0; dlyApply <= 1'b0; postDiv <= 1'b0; achievedHz <= '0;
    end else if (cmd.commit) begin
      srcSel     <= srcIsPll;
      preExp     <= expN[EXP_W-1:0];
      linDiv     <= divVal[DIV_W-1:0];
      oclkDly    <= applied ? oBand : 3'd0;
      sclkDly    <= applied ? sBand : 3'd0;
      dlyApply   <= applied;
      postDiv    <= ddrQ;
      achievedHz <= quoQ;
    end
  end

  // R4
  lin_div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.commit |=> (linDiv >= DIV_W'(1) && linDiv <= DIV_W'(DIV_MAX)));

  // R5
  settings_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.commit |=> ($stable(linDiv) && $stable(preExp) && $stable(srcSel)
                     && $stable(achievedHz) && $stable(oclkDly)));

  // R10
  achieved_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.commit |=> (achievedHz <= (srcSel ? PLL_V : OSC_V)));
endmodule

// File: rtl/clkcalc_ctrl.sv
module clkcalc_ctrl
  import clkcalc_pkg::*;
#(
  parameter int FREQ_W = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  calc_stat_t stat,
  output calc_cmd_t  cmd,
  output logic       busy,
  output logic       done,
  output logic       err
);
  localparam int CNT_W = $clog2(FREQ_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FREQ_W - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_DIV1, S_CEIL, S_FOLD, S_DIV2, S_FIN, S_FAIL
  } state_t;

  state_t state, nextState;
  logic [CNT_W-1:0] stepCnt;
  logic inDiv;

  assign inDiv = (state == S_DIV1) || (state == S_DIV2);
  assign busy  = (state != S_IDLE);

  always_comb begin
    cmd = '0;
    nextState = state;
    case (state)
      S_IDLE:  if (start) begin cmd.capture = 1'b1; nextState = S_CHECK; end
      S_CHECK: if (stat.zeroReq) nextState = S_FAIL;
               else begin cmd.init1 = 1'b1; nextState = S_DIV1; end
      S_DIV1:  begin cmd.divStep = 1'b1; if (stepCnt == LAST) nextState = S_CEIL; end
      S_CEIL:  begin cmd.takeCeil = 1'b1; nextState = S_FOLD; end
      S_FOLD:  if (stat.expOver) nextState = S_FAIL;
               else if (stat.foldNeed) cmd.foldStep = 1'b1;
               else begin cmd.init2 = 1'b1; nextState = S_DIV2; end
      S_DIV2:  begin cmd.divStep = 1'b1; if (stepCnt == LAST) nextState = S_FIN; end
      S_FIN:   begin cmd.commit = 1'b1; nextState = S_IDLE; end
      S_FAIL:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; stepCnt <= '0; done <= 1'b0; err <= 1'b0;
    end else begin
      state   <= nextState;
      stepCnt <= (inDiv && stepCnt != LAST) ? stepCnt + 1'b1 : '0;
      done    <= (state == S_FIN) || (state == S_FAIL);
      if (state == S_FIN)  err <= 1'b0;
      if (state == S_FAIL) err <= 1'b1;
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/clk_div_calc.sv
module clk_div_calc
  import clkcalc_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int OSC_HZ  = 24_000_000,
  parameter int PLL_HZ  = 600_000_000,
  parameter int DIV_MAX = 16,
  parameter int EXP_MAX = 3,
  localparam int DIV_W = $clog2(DIV_MAX + 1),
  localparam int EXP_W = $clog2(EXP_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] reqHz,
  input  logic              newMode,
  input  logic              ddrMode,
  input  logic              calMode,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              srcSel,
  output logic [EXP_W-1:0]  preExp,
  output logic [DIV_W-1:0]  linDiv,
  output logic [2:0]        oclkDly,
  output logic [2:0]        sclkDly,
  output logic              dlyApply,
  output logic              postDiv,
  output logic [FREQ_W-1:0] achievedHz
);
  calc_cmd_t  cmd;
  calc_stat_t stat;

  clkcalc_ctrl #(.FREQ_W(FREQ_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .stat(stat), .cmd(cmd),
    .busy(busy), .done(done), .err(err)
  );

  clkcalc_dp #(
    .FREQ_W(FREQ_W), .OSC_HZ(OSC_HZ), .PLL_HZ(PLL_HZ),
    .DIV_MAX(DIV_MAX), .EXP_MAX(EXP_MAX)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .stat(stat),
    .reqHz(reqHz), .newMode(newMode), .ddrMode(ddrMode), .calMode(calMode),
    .srcSel(srcSel), .preExp(preExp), .linDiv(linDiv),
    .oclkDly(oclkDly), .sclkDly(sclkDly), .dlyApply(dlyApply),
    .postDiv(postDiv), .achievedHz(achievedHz)
  );
endmodule

// File: tb/clk_div_calc_tb.sv
module clk_div_calc_tb;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] reqHz = '0;
  logic newMode = 1'b0, ddrMode = 1'b0, calMode = 1'b0;
  logic busy, done, err, srcSel, dlyApply, postDiv;
  logic [1:0] preExp;
  logic [4:0] linDiv;
  logic [2:0] oclkDly, sclkDly;
  logic [31:0] achievedHz;

  int nChecks = 0, nFail = 0;
  // last successful expected settings
  longint gSrc = 0, gExp = 0, gDiv = 0, gO = 0, gS = 0, gApp = 0, gPd = 0, gAch = 0;

  always #5 clk = ~clk;

  clk_div_calc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .reqHz(reqHz),
    .newMode(newMode), .ddrMode(ddrMode), .calMode(calMode),
    .busy(busy), .done(done), .err(err), .srcSel(srcSel), .preExp(preExp),
    .linDiv(linDiv), .oclkDly(oclkDly), .sclkDly(sclkDly),
    .dlyApply(dlyApply), .postDiv(postDiv), .achievedHz(achievedHz)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  // independent model written from the requirements
  task automatic model(input longint req, input bit nm, input bit dm, input bit cm,
                       output bit e, output longint src, output longint n,
                       output longint d, output longint o, output longint s,
                       output longint app, output longint pd, output longint ach);
    longint h, sHz;
    h = req * (nm ? 2 : 1) * (dm ? 2 : 1);
    e = 0; src = 0; n = 0; d = 0; o = 0; s = 0; app = 0; pd = 0; ach = 0;
    if (req == 0) begin e = 1; return; end
    src = (h > 24_000_000) ? 1 : 0;
    sHz = src ? 600_000_000 : 24_000_000;
    d = (sHz + h - 1) / h;
    while (d > 16) begin n++; d = (d + 1) / 2; end
    if (n > 3) begin e = 1; return; end
    if (h <= 400_000) begin o = 0; s = 0; end
    else if (h <= 25_000_000) begin o = 0; s = 5; end
    else if (h <= 52_000_000) begin o = 3; s = 4; end
    else begin o = 1; s = 4; end
    app = (!nm && !cm) ? 1 : 0;
    if (app == 0) begin o = 0; s = 0; end
    pd = dm ? 1 : 0;
    ach = (sHz >> n) / d;
  endtask

  task automatic waitDone(output bit ok);
    ok = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; return; end
    end
  endtask

  task automatic checkSettings(input string tag, input longint src, input longint n,
      input longint d, input longint o, input longint s, input longint app,
      input longint pd, input longint ach);
    chk(srcSel == src[0], {tag, " srcSel R3"}, srcSel, src);
    chk(preExp == n[1:0], {tag, " preExp R4"}, preExp, n);
    chk(linDiv == d[4:0], {tag, " linDiv R4"}, linDiv, d);
    chk(oclkDly == o[2:0] && sclkDly == s[2:0], {tag, " delays R7"}, {oclkDly, sclkDly}, {o[2:0], s[2:0]});
    chk(dlyApply == app[0], {tag, " dlyApply R8"}, dlyApply, app);
    chk(postDiv == pd[0], {tag, " postDiv R9"}, postDiv, pd);
    chk(achievedHz == ach[31:0], {tag, " achieved R10"}, achievedHz, ach);
  endtask

  // one request, start to done, with all results checked
  task automatic runCase(input longint req, input bit nm, input bit dm, input bit cm,
                         input string tag, input bit pokeBusy);
    bit e, ok;
    longint src, n, d, o, s, app, pd, ach;
    model(req, nm, dm, cm, e, src, n, d, o, s, app, pd, ach);
    @(negedge clk);
    reqHz = req[31:0]; newMode = nm; ddrMode = dm; calMode = cm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {tag, " busy after start R11"}, busy, 1);
    if (pokeBusy) begin
      repeat (5) @(negedge clk);
      reqHz = 32'd1000; newMode = 1'b1; start = 1'b1;  // R11: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    waitDone(ok);
    chk(ok, {tag, " done seen R11"}, ok, 1);
    chk(err == e, {tag, " err R5 R6"}, err, e);
    chk(!busy, {tag, " idle at done R11"}, busy, 0);
    if (e) checkSettings({tag, " held"}, gSrc, gExp, gDiv, gO, gS, gApp, gPd, gAch);
    else begin
      checkSettings(tag, src, n, d, o, s, app, pd, ach);
      gSrc = src; gExp = n; gDiv = d; gO = o; gS = s; gApp = app; gPd = pd; gAch = ach;
    end
    @(negedge clk);
    chk(!done, {tag, " done one cycle R11"}, done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL R11 watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !err, "R1 control reset", {busy, done, err}, 0);
    chk(linDiv == 0 && preExp == 0 && srcSel == 0 && achievedHz == 0, "R1 settings reset", linDiv, 0);
    chk(oclkDly == 0 && sclkDly == 0 && !dlyApply && !postDiv, "R1 delay reset", oclkDly, 0);
    rst_n = 1'b1;
    // R4 R7: oscillator, two folds, slowest band
    runCase(400_000, 0, 0, 0, "R4 identification rate", 0);
    // R3: PLL at the 52 MHz band limit
    runCase(52_000_000, 0, 0, 0, "R3 pll 52M", 0);
    // R2 R8: new mode doubles and suppresses delays
    runCase(52_000_000, 1, 0, 0, "R2 new mode", 0);
    // R9: DDR doubles and sets post-divide
    runCase(52_000_000, 0, 1, 0, "R9 ddr", 0);
    // R2: both flags give 4x
    runCase(13_000_000, 1, 1, 0, "R2 quad", 0);
    // R8: calibration suppresses delays
    runCase(25_000_000, 0, 0, 1, "R8 calibrate", 0);
    // R7 band limits
    runCase(25_000_000, 0, 0, 0, "R7 25M edge", 0);
    runCase(25_000_001, 0, 0, 0, "R7 above 25M", 0);
    runCase(400_001, 0, 0, 0, "R7 above 400k", 0);
    // R3 source limit
    runCase(24_000_000, 0, 0, 0, "R3 24M edge", 0);
    runCase(24_000_001, 0, 0, 0, "R3 above 24M", 0);
    // R4: exactly three folds
    runCase(200_000, 0, 0, 0, "R4 three folds", 0);
    // R5: fourth fold needed -> error, settings held
    runCase(100_000, 0, 0, 0, "R5 exponent overflow", 0);
    // R6: zero request
    runCase(0, 0, 0, 0, "R6 zero", 0);
    // R10 after error recovery
    runCase(50_000_000, 0, 0, 0, "R10 recover", 0);
    // R11: start during busy ignored
    runCase(10_000_000, 0, 0, 0, "R11 busy start", 1);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule